// File: doc/BRIEF.md
# Multi-Mode Host Bus Interface

This block sits between a host processor's 16-bit bidirectional address/data bus and a bank of internal registers. The register bank itself lives outside the block. The host picks one of six bus modes by writing a configuration register. The modes differ in three ways: the data width (16 or 8 bits), whether the address is multiplexed onto the data lines, and, for the 8-bit modes, whether the upper byte carries a separate register address. Two modes carry no address on the bus at all. In those modes every access goes to the register named by an internal pointer, and the host loads that pointer with a dedicated pointer-write cycle.

The block turns each host strobe into a register write pulse, a register read with two cycles of internal latency, or an interrupt-acknowledge vector phase. It drives the bus output enables one byte lane at a time. It also produces a single active-low handshake output. The level of the channel-select pin during the configuration write decides how that output behaves: it is either a wait signal (low while the host must hold off) or a ready signal (low once data or the vector is valid, or once the write has been taken).

Controller states: `S_IDLE`, `S_WR_PUSH`, `S_WR_HOLD`, `S_RD_LAT1`, `S_RD_LAT2`, `S_RD_OUT`, `S_ACK_WAIT`, `S_ACK_OUT`.

Transitions:
- From `S_IDLE`:
  - acknowledge low goes to `S_ACK_WAIT`; this has the highest priority.
  - read strobe goes to `S_RD_LAT1`.
  - configuration or pointer write goes to `S_WR_HOLD`.
  - register write goes to `S_WR_PUSH`.
- `S_WR_PUSH` goes to `S_WR_HOLD`.
- `S_RD_LAT1` goes to `S_RD_LAT2`, then to `S_RD_OUT`.
- From `S_ACK_WAIT`:
  - vector valid goes to `S_ACK_OUT`.
  - acknowledge released goes to `S_IDLE`.
- `S_RD_OUT`, `S_WR_HOLD` and `S_ACK_OUT` each return to `S_IDLE` when their strobe is released.

Top module: `hostbus_if`

## Requirements
- R1: After reset:
  - the mode code is 0 and the handshake is in wait style;
  - the pointer is 0 and the controller is in `S_IDLE`;
  - `ad_oe` is 00, `hs_n` is 1, and `reg_we` and `reg_re` are 0.
- R2: A write cycle (`cs_n`=0, `wr_n`=0) with `cfg_sel`=1 loads the mode code from `ad_in[2:0]`:
  - 0: 16-bit pointer-addressed;
  - 1: 8-bit pointer-addressed;
  - 2: 8-bit with the address on the high byte;
  - 3: 16-bit multiplexed;
  - 4: 8-bit multiplexed;
  - 5: 8-bit multiplexed with the address on the high byte;
  - codes 6 and 7 select code 0.
  
  The same write samples `ch_sel`: 1 selects wait style and 0 selects ready style. It raises no `reg_we`.
- R3: A write cycle with `ptr_sel`=1 loads the pointer from `ad_in[7:0]` and raises no `reg_we`. In modes 0 and 1, every register access uses the pointer as its address, and accesses leave the pointer unchanged.
- R4: In modes 2 and 5, the register address is `ad_in[15:8]` at the edge that accepts the request.
- R5: In modes 3 and 4, a cycle with `as_stb`=1 latches `ad_in[7:0]` as the address for later accesses. `as_stb` has no effect in the other modes.
- R6: A register write pulses `reg_we` for exactly the one cycle after the accepting edge.
  - Modes 0 and 3 write all 16 bits of `ad_in`.
  - The 8-bit modes write {8'h00, `ad_in[7:0]`} and ignore the high byte.
- R7: A read pulses `reg_re` for the one cycle after the accepting edge. `reg_rdata` is captured two edges later, and from the third edge the data is driven.
  - Modes 0 and 3: `ad_oe`=11 and `ad_out`=`reg_rdata`.
  - 8-bit modes: `ad_oe`=01 and `ad_out`={8'h00, low byte}.
- R8: `ad_oe` is 00 except while a read data phase or a vector phase is in progress and its strobe is still held.
- R9: In wait style, `hs_n` is 0 while a request is active and not yet complete, and 1 otherwise.
- R10: In ready style, `hs_n` is 0 only while a request is active and complete (data or vector driven, or write taken), and 1 otherwise.
- R11: When `iack_n` goes low, the block waits for `vec_valid`, captures `vec_in` at that edge, and drives the vector under the same lane rules as R7. The acknowledge takes precedence over a simultaneous read strobe, which then raises no `reg_re`.
- R12: Once the strobes are released, `ad_oe` is 00 at once. After the next edge, `hs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| as_stb | input | 1 | Address strobe for the multiplexed modes |
| cfg_sel | input | 1 | Marks a write as a configuration write |
| ptr_sel | input | 1 | Marks a write as a pointer write |
| ch_sel | input | 1 | Channel-select level, sampled as the handshake style |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| vec_valid | input | 1 | Vector ready from the interrupt logic |
| vec_in | input | 16 | Interrupt vector |
| ad_in | input | 16 | Bus input lines |
| ad_out | output | 16 | Bus output lines |
| ad_oe | output | 2 | Output enable per byte lane (bit 1 = high byte) |
| hs_n | output | 1 | Wait or ready handshake, active low |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | Register write pulse |
| reg_re | output | 1 | Register read pulse |
| reg_rdata | input | 16 | Register read data |

## Verification
The bench aims at the address source of each mode and at the byte-lane limits of the 8-bit modes:
- A decoder that took the pointer in a separate-address mode, or read the high byte in an 8-bit mode, would hit a wrong register or store stray upper data.
- It pulses `as_stb` in a pointer mode and then reads in a multiplexed mode without a new strobe. A design that latched on every strobe would reach the wrong register.
- It samples the handshake in every latency cycle in both styles. An inverted or early handshake, or an output enable that comes a cycle early, is caught.
- It raises a read and an acknowledge together. A design that let the read win would drive register data in place of the vector and pulse `reg_re`.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

    typedef enum logic [2:0] {
        BM_W16_PTR      = 3'd0,
        BM_B8_PTR       = 3'd1,
        BM_B8_HIADR     = 3'd2,
        BM_W16_MUX      = 3'd3,
        BM_B8_MUX       = 3'd4,
        BM_B8_MUX_HIADR = 3'd5
    } bus_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_PUSH,
        S_WR_HOLD,
        S_RD_LAT1,
        S_RD_LAT2,
        S_RD_OUT,
        S_ACK_WAIT,
        S_ACK_OUT
    } hb_state_e;

    function automatic logic mode_is_wide(input bus_mode_e m);
        return (m == BM_W16_PTR) || (m == BM_W16_MUX);
    endfunction

endpackage

// File: rtl/hostbus_cfg.sv
module hostbus_cfg
    import hostbus_pkg::*;
#(
    parameter int HB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          ptr_we,
    input  logic          as_stb,
    input  logic [HB-1:0] ad_lo,
    input  logic          ch_sel,
    output bus_mode_e     mode,
    output logic          style_wait,
    output logic [HB-1:0] ptr,
    output logic [HB-1:0] mux_addr
);

    logic mux_mode;
    assign mux_mode = (mode == BM_W16_MUX) || (mode == BM_B8_MUX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode       <= BM_W16_PTR;
            style_wait <= 1'b1;
            ptr        <= '0;
            mux_addr   <= '0;
        end else begin
            if (cfg_we) begin
                mode       <= (ad_lo[2:0] > 3'd5) ? BM_W16_PTR : bus_mode_e'(ad_lo[2:0]);
                style_wait <= ch_sel;
            end
            if (ptr_we)
                ptr <= ad_lo;
            if (as_stb && mux_mode)
                mux_addr <= ad_lo;
        end
    end

endmodule

// File: rtl/hostbus_steer.sv
module hostbus_steer
    import hostbus_pkg::*;
#(
    parameter int DW = 16,
    localparam int HB = DW / 2
) (
    input  bus_mode_e     mode,
    input  logic [HB-1:0] ptr,
    input  logic [HB-1:0] mux_addr,
    input  logic [DW-1:0] ad_in,
    input  logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] vec_in,
    output logic [HB-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_shaped,
    output logic [DW-1:0] vec_shaped,
    output logic [1:0]    lane_en
);

    logic wide;
    assign wide = mode_is_wide(mode);

    always_comb begin
        unique case (mode)
            BM_W16_PTR, BM_B8_PTR:        addr = ptr;
            BM_B8_HIADR, BM_B8_MUX_HIADR: addr = ad_in[DW-1:HB];
            BM_W16_MUX, BM_B8_MUX:        addr = mux_addr;
            default:                      addr = ptr;
        endcase
    end

    // Lower lane always passes; upper lane only in the wide modes.
    assign lane_en = {wide, 1'b1};

    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        assign wdata[ln*HB +: HB]      = lane_en[ln] ? ad_in[ln*HB +: HB]     : '0;
        assign rd_shaped[ln*HB +: HB]  = lane_en[ln] ? reg_rdata[ln*HB +: HB] : '0;
        assign vec_shaped[ln*HB +: HB] = lane_en[ln] ? vec_in[ln*HB +: HB]    : '0;
    end

endmodule

// File: rtl/hostbus_fsm.sv
module hostbus_fsm
    import hostbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic iack_n,
    input  logic cfg_sel,
    input  logic ptr_sel,
    input  logic vec_valid,
    input  logic style_wait,
    output logic cfg_we,
    output logic ptr_we,
    output logic cap_addr,
    output logic reg_we,
    output logic reg_re,
    output logic cap_rd,
    output logic cap_vec,
    output logic drive,
    output logic hs_n
);

    hb_state_e st, nxt;
    logic rd_act, wr_act, ack_act, active, done;

    assign rd_act  = !cs_n && !rd_n;
    assign wr_act  = !cs_n && !wr_n;
    assign ack_act = !iack_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: begin
                if (ack_act)                       nxt = S_ACK_WAIT;
                else if (rd_act)                   nxt = S_RD_LAT1;
                else if (wr_act && (cfg_sel || ptr_sel)) nxt = S_WR_HOLD;
                else if (wr_act)                   nxt = S_WR_PUSH;
            end
            S_WR_PUSH:  nxt = S_WR_HOLD;
            S_WR_HOLD:  if (!wr_act)  nxt = S_IDLE;
            S_RD_LAT1:  nxt = S_RD_LAT2;
            S_RD_LAT2:  nxt = S_RD_OUT;
            S_RD_OUT:   if (!rd_act)  nxt = S_IDLE;
            S_ACK_WAIT: begin
                if (!ack_act)       nxt = S_IDLE;
                else if (vec_valid) nxt = S_ACK_OUT;
            end
            S_ACK_OUT:  if (!ack_act) nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    always_comb begin
        cfg_we   = 1'b0;
        ptr_we   = 1'b0;
        cap_addr = 1'b0;
        reg_we   = 1'b0;
        reg_re   = 1'b0;
        cap_rd   = 1'b0;
        cap_vec  = 1'b0;
        drive    = 1'b0;
        done     = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (!ack_act && !rd_act && wr_act) begin
                    cfg_we   = cfg_sel;
                    ptr_we   = !cfg_sel && ptr_sel;
                    cap_addr = !cfg_sel && !ptr_sel;
                end else if (!ack_act && rd_act) begin
                    cap_addr = 1'b1;
                end
            end
            S_WR_PUSH:  reg_we = 1'b1;
            S_WR_HOLD:  done = 1'b1;
            S_RD_LAT1:  reg_re = 1'b1;
            S_RD_LAT2:  cap_rd = 1'b1;
            S_RD_OUT: begin
                done  = 1'b1;
                drive = rd_act;
            end
            S_ACK_WAIT: cap_vec = ack_act && vec_valid;
            S_ACK_OUT: begin
                done  = 1'b1;
                drive = ack_act;
            end
            default: ;
        endcase
        active = ack_act || rd_act || wr_act;
        hs_n   = style_wait ? !(active && !done) : !(active && done);
    end

endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
    import hostbus_pkg::*;
#(
    parameter int DW = 16,
    localparam int HB = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          as_stb,
    input  logic          cfg_sel,
    input  logic          ptr_sel,
    input  logic          ch_sel,
    input  logic          iack_n,
    input  logic          vec_valid,
    input  logic [DW-1:0] vec_in,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic [1:0]    ad_oe,
    output logic          hs_n,
    output logic [HB-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);

    bus_mode_e     mode_q;
    logic          style_wait_q;
    logic [HB-1:0] ptr_q, mux_addr_q, addr_sel, addr_q;
    logic [DW-1:0] wdata_sel, rd_shaped, vec_shaped, wdata_q, dout_q;
    logic [1:0]    lane_en;
    logic          cfg_we, ptr_we, cap_addr, cap_rd, cap_vec, drive;

    hostbus_cfg #(.HB(HB)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .ptr_we    (ptr_we),
        .as_stb    (as_stb),
        .ad_lo     (ad_in[HB-1:0]),
        .ch_sel    (ch_sel),
        .mode      (mode_q),
        .style_wait(style_wait_q),
        .ptr       (ptr_q),
        .mux_addr  (mux_addr_q)
    );

    hostbus_steer #(.DW(DW)) u_steer (
        .mode      (mode_q),
        .ptr       (ptr_q),
        .mux_addr  (mux_addr_q),
        .ad_in     (ad_in),
        .reg_rdata (reg_rdata),
        .vec_in    (vec_in),
        .addr      (addr_sel),
        .wdata     (wdata_sel),
        .rd_shaped (rd_shaped),
        .vec_shaped(vec_shaped),
        .lane_en   (lane_en)
    );

    hostbus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .iack_n    (iack_n),
        .cfg_sel   (cfg_sel),
        .ptr_sel   (ptr_sel),
        .vec_valid (vec_valid),
        .style_wait(style_wait_q),
        .cfg_we    (cfg_we),
        .ptr_we    (ptr_we),
        .cap_addr  (cap_addr),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .cap_rd    (cap_rd),
        .cap_vec   (cap_vec),
        .drive     (drive),
        .hs_n      (hs_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            dout_q  <= '0;
        end else begin
            if (cap_addr) begin
                addr_q  <= addr_sel;
                wdata_q <= wdata_sel;
            end
            if (cap_rd)       dout_q <= rd_shaped;
            else if (cap_vec) dout_q <= vec_shaped;
        end
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign ad_out    = dout_q;
    assign ad_oe     = drive ? lane_en : 2'b00;

endmodule

// File: rtl/hostbus_chk.sv
module hostbus_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       iack_n,
    input logic [1:0] ad_oe,
    input logic       hs_n,
    input logic       reg_we,
    input logic       reg_re,
    input logic [2:0] mode,
    input logic       style_wait
);

    // R8
    oe_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe != 2'b00) |-> (!iack_n || (!cs_n && !rd_n)));

    // R6
    we_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(!cs_n && !wr_n));

    // R7
    re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R7
    hi_lane_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe[1] |-> (mode == 3'd0 || mode == 3'd3));

    // R9
    hs_when_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe[0] |-> (hs_n == style_wait));

endmodule

bind hostbus_if hostbus_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .iack_n    (iack_n),
    .ad_oe     (ad_oe),
    .hs_n      (hs_n),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .mode      (mode_q),
    .style_wait(style_wait_q)
);

// File: tb/sim_hostbus_if.sv
module sim_hostbus_if;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, as_stb = 1'b0;
    logic        cfg_sel = 1'b0, ptr_sel = 1'b0, ch_sel = 1'b1;
    logic        iack_n = 1'b1, vec_valid = 1'b0;
    logic [15:0] vec_in = '0, ad_in = '0;
    logic [15:0] ad_out, reg_wdata, reg_rdata;
    logic [1:0]  ad_oe;
    logic        hs_n, reg_we, reg_re;
    logic [7:0]  reg_addr;

    int n_chk = 0, n_fail = 0;
    int we_cnt = 0, re_cnt = 0;
    logic [7:0]  we_addr = '0, re_addr = '0;
    logic [15:0] we_data = '0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign reg_rdata = {~reg_addr, reg_addr};

    hostbus_if u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .as_stb(as_stb), .cfg_sel(cfg_sel), .ptr_sel(ptr_sel), .ch_sel(ch_sel),
        .iack_n(iack_n), .vec_valid(vec_valid), .vec_in(vec_in), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .hs_n(hs_n), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_we) begin
            we_cnt  <= we_cnt + 1;
            we_addr <= reg_addr;
            we_data <= reg_wdata;
        end
        if (reg_re) begin
            re_cnt  <= re_cnt + 1;
            re_addr <= reg_addr;
        end
    end

    typedef struct packed {
        logic [2:0]  mode;
        logic        rd;
        logic [7:0]  ptr;
        logic [7:0]  asa;
        logic [15:0] ad;
        logic [7:0]  ea;
        logic [15:0] ed;
        logic [1:0]  eoe;
    } vec_t;

    localparam vec_t TBL [0:11] = '{
        '{3'd0, 1'b0, 8'h12, 8'h00, 16'hBEEF, 8'h12, 16'hBEEF, 2'b00},
        '{3'd0, 1'b1, 8'h34, 8'h00, 16'h5555, 8'h34, 16'hCB34, 2'b11},
        '{3'd1, 1'b0, 8'h56, 8'h00, 16'hA1B2, 8'h56, 16'h00B2, 2'b00},
        '{3'd1, 1'b1, 8'h78, 8'h00, 16'h9999, 8'h78, 16'h0078, 2'b01},
        '{3'd2, 1'b0, 8'h11, 8'h00, 16'h9AC3, 8'h9A, 16'h00C3, 2'b00},
        '{3'd2, 1'b1, 8'h11, 8'h00, 16'h4D00, 8'h4D, 16'h004D, 2'b01},
        '{3'd3, 1'b0, 8'h11, 8'h21, 16'h7E6F, 8'h21, 16'h7E6F, 2'b00},
        '{3'd3, 1'b1, 8'h11, 8'h43, 16'h0000, 8'h43, 16'hBC43, 2'b11},
        '{3'd4, 1'b0, 8'h11, 8'h65, 16'hFF19, 8'h65, 16'h0019, 2'b00},
        '{3'd5, 1'b1, 8'h11, 8'h99, 16'h2A77, 8'h2A, 16'h002A, 2'b01},
        '{3'd5, 1'b0, 8'h44, 8'h99, 16'h3C80, 8'h3C, 16'h0080, 2'b00},
        '{3'd4, 1'b1, 8'h11, 8'h0F, 16'h0000, 8'h0F, 16'h000F, 2'b01}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string addr_tag(input logic [2:0] m);
        if (m == 3'd2 || m == 3'd5) return "R4";
        if (m == 3'd3 || m == 3'd4) return "R5";
        return "R3";
    endfunction

    task automatic cfg_wr(input logic [2:0] m, input bit chs);
        @(negedge clk);
        cs_n = 0; wr_n = 0; cfg_sel = 1; ch_sel = chs; ad_in = {13'h0, m};
        @(negedge clk);
        cs_n = 1; wr_n = 1; cfg_sel = 0;
        @(negedge clk);
    endtask

    task automatic ptr_wr(input logic [7:0] p);
        @(negedge clk);
        cs_n = 0; wr_n = 0; ptr_sel = 1; ad_in = {8'hC7, p};
        @(negedge clk);
        cs_n = 1; wr_n = 1; ptr_sel = 0;
        @(negedge clk);
    endtask

    task automatic as_pulse(input logic [15:0] a);
        @(negedge clk);
        as_stb = 1; ad_in = a;
        @(negedge clk);
        as_stb = 0;
    endtask

    task automatic wr_op(input bit ws, input logic [15:0] d);
        string ht = ws ? "R9" : "R10";
        @(negedge clk);
        cs_n = 0; wr_n = 0; ad_in = d;
        @(negedge clk);
        chk(reg_we == 1'b1, "R6", "we pulse", reg_we, 1);
        chk(ad_oe == 2'b00, "R8", "oe during write", ad_oe, 0);
        chk(hs_n == !ws, ht, "hs before accept", hs_n, !ws);
        @(negedge clk);
        chk(reg_we == 1'b0, "R6", "we single", reg_we, 0);
        chk(hs_n == ws, ht, "hs write taken", hs_n, ws);
        cs_n = 1; wr_n = 1;
        @(negedge clk);
        chk(hs_n == 1'b1 && ad_oe == 2'b00, "R12", "after write release", {hs_n, ad_oe}, 3'b100);
    endtask

    task automatic rd_op(input bit ws, input logic [15:0] a,
                         output logic [15:0] d, output logic [1:0] oe);
        string ht = ws ? "R9" : "R10";
        @(negedge clk);
        cs_n = 0; rd_n = 0; ad_in = a;
        @(negedge clk);
        chk(reg_re == 1'b1, "R7", "re pulse", reg_re, 1);
        chk(ad_oe == 2'b00, "R8", "oe latency1", ad_oe, 0);
        chk(hs_n == !ws, ht, "hs latency1", hs_n, !ws);
        @(negedge clk);
        chk(reg_re == 1'b0, "R7", "re single", reg_re, 0);
        chk(ad_oe == 2'b00, "R8", "oe latency2", ad_oe, 0);
        chk(hs_n == !ws, ht, "hs latency2", hs_n, !ws);
        @(negedge clk);
        d = ad_out; oe = ad_oe;
        chk(hs_n == ws, ht, "hs data valid", hs_n, ws);
        cs_n = 1; rd_n = 1;
        #1;
        chk(ad_oe == 2'b00, "R12", "oe at release", ad_oe, 0);
        @(negedge clk);
        chk(hs_n == 1'b1 && ad_oe == 2'b00, "R12", "after read release", {hs_n, ad_oe}, 3'b100);
    endtask

    task automatic ack_op(input bit ws, input logic [15:0] v, input bit with_rd,
                          input logic [15:0] eo, input logic [1:0] eoe);
        string ht = ws ? "R9" : "R10";
        int re0 = re_cnt;
        @(negedge clk);
        iack_n = 0; vec_valid = 0;
        if (with_rd) begin cs_n = 0; rd_n = 0; end
        @(negedge clk);
        chk(ad_oe == 2'b00, "R11", "oe awaiting vector", ad_oe, 0);
        chk(hs_n == !ws, ht, "hs awaiting vector", hs_n, !ws);
        @(negedge clk);
        chk(ad_oe == 2'b00, "R11", "oe still awaiting", ad_oe, 0);
        vec_valid = 1; vec_in = v;
        @(negedge clk);
        chk(ad_out == eo, "R11", "vector out", ad_out, eo);
        chk(ad_oe == eoe, "R11", "vector lanes", ad_oe, eoe);
        chk(hs_n == ws, ht, "hs vector valid", hs_n, ws);
        iack_n = 1; vec_valid = 0; cs_n = 1; rd_n = 1;
        @(negedge clk);
        chk(ad_oe == 2'b00, "R12", "oe after ack", ad_oe, 0);
        chk(re_cnt == re0, "R11", "no read during ack", re_cnt, re0);
    endtask

    initial begin
        logic [15:0] d;
        logic [1:0]  oe;
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ad_oe == 2'b00 && hs_n == 1'b1, "R1", "reset outputs", {ad_oe, hs_n}, 3'b001);
        chk(reg_we == 1'b0 && reg_re == 1'b0, "R1", "reset strobes", {reg_we, reg_re}, 0);
        rd_op(1'b1, 16'h0000, d, oe);
        chk(re_addr == 8'h00, "R1", "reset pointer", re_addr, 0);
        chk(d == 16'hFF00 && oe == 2'b11, "R1", "reset mode wide", {d, oe}, {16'hFF00, 2'b11});

        for (int i = 0; i < 12; i++) begin
            cfg_wr(TBL[i].mode, 1'b1);
            ptr_wr(TBL[i].ptr);
            as_pulse({8'hEE, TBL[i].asa});
            if (TBL[i].rd) begin
                rd_op(1'b1, TBL[i].ad, d, oe);
                chk(re_addr == TBL[i].ea, addr_tag(TBL[i].mode), "read addr", re_addr, TBL[i].ea);
                chk(d == TBL[i].ed, "R7", "read data", d, TBL[i].ed);
                chk(oe == TBL[i].eoe, "R7", "read lanes", oe, TBL[i].eoe);
            end else begin
                w0 = we_cnt;
                wr_op(1'b1, TBL[i].ad);
                chk(we_cnt == w0 + 1, "R6", "one write", we_cnt, w0 + 1);
                chk(we_addr == TBL[i].ea, addr_tag(TBL[i].mode), "write addr", we_addr, TBL[i].ea);
                chk(we_data == TBL[i].ed, "R6", "write data", we_data, TBL[i].ed);
            end
        end

        // R5: address strobe ignored in a pointer mode
        cfg_wr(3'd0, 1'b1);
        as_pulse(16'h00AB);
        cfg_wr(3'd3, 1'b1);
        rd_op(1'b1, 16'h0000, d, oe);
        chk(re_addr == 8'h0F, "R5", "strobe ignored in mode 0", re_addr, 8'h0F);

        // R3: pointer persists over accesses
        cfg_wr(3'd0, 1'b1);
        ptr_wr(8'h5A);
        rd_op(1'b1, 16'h0000, d, oe);
        rd_op(1'b1, 16'h0000, d, oe);
        chk(re_addr == 8'h5A && d == 16'hA55A, "R3", "pointer kept", {re_addr, d}, {8'h5A, 16'hA55A});

        // R2: illegal code falls back to mode 0, config and pointer writes raise no we
        w0 = we_cnt;
        cfg_wr(3'd7, 1'b1);
        ptr_wr(8'h3C);
        chk(we_cnt == w0, "R2", "no we on cfg/ptr", we_cnt, w0);
        rd_op(1'b1, 16'h0000, d, oe);
        chk(d == 16'hC33C && oe == 2'b11, "R2", "code 7 as mode 0", {d, oe}, {16'hC33C, 2'b11});

        // R10: ready style
        cfg_wr(3'd0, 1'b0);
        ptr_wr(8'h01);
        rd_op(1'b0, 16'h0000, d, oe);
        chk(d == 16'hFE01, "R10", "ready style read data", d, 16'hFE01);
        wr_op(1'b0, 16'h1357);
        chk(we_data == 16'h1357, "R10", "ready style write", we_data, 16'h1357);

        // R11: acknowledge cycles
        cfg_wr(3'd0, 1'b1);
        ack_op(1'b1, 16'h1234, 1'b0, 16'h1234, 2'b11);
        cfg_wr(3'd1, 1'b0);
        ack_op(1'b0, 16'h5678, 1'b1, 16'h0078, 2'b01);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule